// File: doc/BRIEF.md
# Dual-Lane Double-Rate SPI Master with Cable Delay Compensation

This block is an SPI master for a remote acquisition device that sits at the far end of a long cable. It drives a divided serial clock, an active-low chip select and one outgoing data line. Read data comes back on two lanes, A and B. Each lane carries a new bit after every serial clock edge, both rising and falling.

The cable delays the returning data by many clock edges. To cope with this, the block keeps a history of the edges it has sent. It captures incoming data only once a programmed number of edges has passed since the matching outgoing edge. The chip select stays low and the serial clock keeps running after the last outgoing bit, until every delayed return bit has been captured.

The user side is a plain command port. The user presents a 16-bit transmit word and a delay setting, then pulses `start`. The block returns a 64-bit receive word with a one-cycle valid strobe.

Top module: `dual_ddr_spi_master`

## Requirements
- R1: After reset the block is idle. In the idle state `cs_n` is 1, `sclk` is 0, `mosi` is 0, `busy` is 0 and `rx_valid` is 0.
- R2: `sclk` is low whenever `cs_n` is high. Each half period of `sclk` lasts `HALF_DIV` system clocks. The first edge is a rising edge, `HALF_DIV` clocks after `cs_n` falls.
- R3: `mosi` sends the transmit word MSB first, one bit per `sclk` period, 16 bits in all. `mosi` changes only at falling edges, so it is stable across every rising edge. After the 16th bit it is 0.
- R4: Frame edge e runs from 0 to 31, with even e being a rising edge. The lane A bit for edge e lands in `rx_word[63-2e]` and the lane B bit lands in `rx_word[62-2e]`. Within a cycle the rising-edge pair therefore comes before the falling-edge pair.
- R5: Let D be the delay setting. The return data for frame edge e is expected on `miso_a`/`miso_b` during the half period that follows outgoing edge e+D. Each lane passes through a two-flop synchronizer and is sampled at the end of that half period, which requires `HALF_DIV` of at least 3.
- R6: `delay_cfg` is sampled only when a transfer starts. Any value above 32 is treated as 32. A change to `delay_cfg` during a transfer has no effect on that transfer.
- R7: For an effective delay D, `cs_n` stays low for (33+D)·`HALF_DIV` clocks. During that time `sclk` gives 16+ceil(D/2) rising edges, and it ends low.
- R8: `rx_valid` is high for exactly one clock. That clock is the one in which `cs_n` returns high, and `rx_word` holds the complete frame during it.
- R9: A `start` pulse while `busy` is 1 is ignored. It launches no extra transfer, and neither the transmit word nor the delay of the running transfer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a transfer when idle |
| tx_word | input | 16 | Word to send on `mosi`, MSB first |
| delay_cfg | input | 6 | Round-trip compensation in `sclk` edges (0..32, larger values clamp) |
| busy | output | 1 | High while a transfer runs |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso_a | input | 1 | Return data lane A, one bit per edge |
| miso_b | input | 1 | Return data lane B, one bit per edge |
| rx_word | output | 64 | Assembled receive frame |
| rx_valid | output | 1 | One-cycle strobe: `rx_word` is complete |

## Verification
The cable model delays return data by whole edges, so a capture tap that is off by one edge shows up as a frame shifted by one lane pair. A lane or edge swap shows up as bits exchanged in `rx_word`. Delays of 0, 1, 8, 15, 16 and 32 cover both parities of D and the deepest tap, where a design that ended the frame too early would lose the final pairs and report the wrong count of rising edges. A setting of 40 checks the clamp. A mid-transfer `start` together with a new delay setting would show up as a second valid strobe or a corrupted frame if the design did not ignore it.

// File: rtl/dual_ddr_spi_master.sv
module dual_ddr_spi_master #(
  parameter int HALF_DIV = 4,
  parameter int FRAME    = 16,
  parameter int MAX_DLY  = 32,
  parameter int DLY_W    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME-1:0]   tx_word,
  input  logic [DLY_W-1:0]   delay_cfg,
  output logic               busy,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso_a,
  input  logic               miso_b,
  output logic [4*FRAME-1:0] rx_word,
  output logic               rx_valid
);

  localparam int EDGES = 2 * FRAME;
  localparam int RXW   = 4 * FRAME;
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int EV_W  = $clog2(EDGES + MAX_DLY + 2);
  localparam int CAP_W = $clog2(EDGES);
  localparam logic [DLY_W-1:0] DMAX     = DLY_W'(MAX_DLY);
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(HALF_DIV - 1);
  localparam logic [EV_W-1:0]  EV_FRAME = EV_W'(EDGES);
  localparam logic [CAP_W-1:0] CAP_LAST = CAP_W'(EDGES - 1);

  logic [CNT_W-1:0] div_cnt;
  logic [EV_W-1:0]  ev_cnt;
  logic [CAP_W-1:0] cap_cnt;
  logic [MAX_DLY:0] hist;
  logic [DLY_W-1:0] dly_q;
  logic [FRAME-1:0] tx_sh;
  logic [RXW-1:0]   rx_sh;
  logic [1:0]       sync_a, sync_b;

  wire [DLY_W-1:0] dly_eff = (delay_cfg > DMAX) ? DMAX : delay_cfg;
  wire tick  = !cs_n && (div_cnt == DIV_LAST);
  wire cap   = tick && hist[dly_q];
  wire last  = cap && (cap_cnt == CAP_LAST);

  assign busy    = !cs_n;
  assign mosi    = !cs_n && tx_sh[FRAME-1];
  assign rx_word = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      rx_valid <= 1'b0;
      div_cnt  <= '0;
      ev_cnt   <= '0;
      cap_cnt  <= '0;
      hist     <= '0;
      dly_q    <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      sync_a   <= '0;
      sync_b   <= '0;
    end else begin
      rx_valid <= 1'b0;
      sync_a   <= {sync_a[0], miso_a};
      sync_b   <= {sync_b[0], miso_b};
      if (cs_n) begin
        if (start) begin
          cs_n    <= 1'b0;
          sclk    <= 1'b0;
          div_cnt <= '0;
          ev_cnt  <= '0;
          cap_cnt <= '0;
          hist    <= '0;
          tx_sh   <= tx_word;
          dly_q   <= dly_eff;
        end
      end else begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (tick) begin
          hist   <= {hist[MAX_DLY-1:0], ev_cnt < EV_FRAME};
          ev_cnt <= ev_cnt + 1'b1;
          if (ev_cnt[0])
            tx_sh <= {tx_sh[FRAME-2:0], 1'b0};
          if (cap) begin
            rx_sh   <= {rx_sh[RXW-3:0], sync_a[1], sync_b[1]};
            cap_cnt <= cap_cnt + 1'b1;
          end
          if (last) begin
            cs_n     <= 1'b1;
            sclk     <= 1'b0;
            rx_valid <= 1'b1;
          end else begin
            sclk <= ~sclk;
          end
        end
      end
    end
  end

  // R8
  rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  valid_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (cs_n && !sclk));

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !sclk);

  // R6
  dly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(dly_q));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && start && !last) |=> !cs_n);

endmodule

// File: tb/sim_dual_ddr_spi_master.sv
`timescale 1ns/1ps
module sim_dual_ddr_spi_master;
  localparam int HALF = 4;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] tx_word = '0;
  logic [5:0]  delay_cfg = '0;
  logic        miso_a = 1'b0, miso_b = 1'b0;
  wire         busy, sclk, cs_n, mosi, rx_valid;
  wire [63:0]  rx_word;

  always #2 clk = ~clk;

  dual_ddr_spi_master #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
    .delay_cfg(delay_cfg), .busy(busy), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso_a(miso_a), .miso_b(miso_b),
    .rx_word(rx_word), .rx_valid(rx_valid));

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  typedef struct { logic [63:0] rx; logic [15:0] tx; int d; } exp_t;
  exp_t q[$];

  // cable and remote device model
  logic [63:0] dev_word = '0;
  int cable_d = 0, ek = 0, dm = 0, rises = 0;
  bit fall_seen = 0;
  logic [15:0] mosi_got = '0;
  realtime t_cs0 = 0, t_cs1 = 0, t_rise0 = 0, t_fall0 = 0;

  always @(negedge cs_n) begin
    ek = 0; rises = 0; mosi_got = '0; fall_seen = 0; t_cs0 = $realtime;
  end
  always @(posedge cs_n) t_cs1 = $realtime;

  always @(sclk) begin
    if (cs_n === 1'b0) begin
      dm = ek - cable_d;
      ek++;
      #1;
      if (dm >= 0 && dm < 32) begin
        miso_a = dev_word[63-2*dm];
        miso_b = dev_word[62-2*dm];
      end else begin
        miso_a = ek[0];
        miso_b = ~ek[0];
      end
    end
  end

  always @(posedge sclk) begin
    if (cs_n === 1'b0) begin
      if (rises == 0) t_rise0 = $realtime;
      if (rises < 16) mosi_got = {mosi_got[14:0], mosi};
      rises++;
    end
  end

  always @(negedge sclk) begin
    if (cs_n === 1'b0 && !fall_seen) begin
      fall_seen = 1;
      t_fall0 = $realtime;
    end
  end

  // monitor: pops expected items as frames complete
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && rx_valid) begin
        if (q.size() == 0) chk(0, "R9", "unexpected rx_valid", 1, 0);
        else begin
          e = q.pop_front();
          // R4 R5 lane/edge order and delay alignment
          chk(rx_word == e.rx, "R4/R5", "rx_word", rx_word, e.rx);
          // R3
          chk(mosi_got == e.tx, "R3", "mosi bits", mosi_got, e.tx);
          // R7
          chk(rises == 16 + (e.d + 1) / 2, "R7", "rising edges", rises, 16 + (e.d + 1) / 2);
          chk(int'((t_cs1 - t_cs0) / 4.0) == (33 + e.d) * HALF, "R7", "cs low clocks",
              int'((t_cs1 - t_cs0) / 4.0), (33 + e.d) * HALF);
          // R2
          chk(int'((t_rise0 - t_cs0) / 4.0) == HALF, "R2", "first rise delay",
              int'((t_rise0 - t_cs0) / 4.0), HALF);
          chk(int'((t_fall0 - t_rise0) / 4.0) == HALF, "R2", "half period",
              int'((t_fall0 - t_rise0) / 4.0), HALF);
          // R8
          chk(cs_n == 1'b1 && sclk == 1'b0, "R8", "cs/sclk at valid", {cs_n, sclk}, 2'b10);
          @(negedge clk);
          chk(rx_valid == 1'b0, "R8", "valid width", rx_valid, 0);
        end
      end
    end
  end

  task automatic xfer(input logic [15:0] tx, input logic [63:0] dw,
                      input int cfg, input int cable, input bit poke);
    exp_t e;
    int d;
    d = (cfg > 32) ? 32 : cfg;
    @(negedge clk);
    dev_word = dw; cable_d = cable; delay_cfg = 6'(cfg); tx_word = tx;
    e.rx = dw; e.tx = tx; e.d = d;
    q.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      // R9
      chk(busy == 1'b1, "R9", "busy mid transfer", busy, 1);
      start = 1'b1; tx_word = ~tx; delay_cfg = 6'd3;   // R6 change ignored
      @(negedge clk);
      start = 1'b0;
    end
    wait (q.size() == 0);
    repeat (4 * HALF) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk({cs_n, sclk, mosi, busy, rx_valid} == 5'b10000, "R1", "reset state",
        {cs_n, sclk, mosi, busy, rx_valid}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({cs_n, sclk, mosi, busy, rx_valid} == 5'b10000, "R1", "idle state",
        {cs_n, sclk, mosi, busy, rx_valid}, 5'b10000);
    xfer(16'hA5C3, 64'h0123_4567_89AB_CDEF, 0, 0, 0);
    xfer(16'hFFFF, 64'hFFFF_0000_AAAA_5555, 1, 1, 0);
    xfer(16'h0001, 64'h8000_0000_0000_0001, 8, 8, 0);
    xfer(16'h8000, 64'hDEAD_BEEF_CAFE_F00D, 15, 15, 0);
    xfer(16'h1234, 64'h5A5A_C3C3_0F0F_9669, 16, 16, 0);
    xfer(16'hABCD, 64'h1357_9BDF_2468_ACE0, 32, 32, 0);
    // R6 clamp: setting 40 behaves as 32
    xfer(16'h0F0F, 64'hF0E1_D2C3_B4A5_9687, 40, 32, 0);
    // R9 and R6: start and new delay while busy
    xfer(16'hC001, 64'h6C6C_3939_A0A0_0505, 9, 9, 1);
    repeat (400) @(negedge clk);
    chk(q.size() == 0 && cs_n == 1'b1, "R9", "no extra transfer", {cs_n, 8'(q.size())}, 9'h100);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule